// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block produces the serial clock for an I2C master. The system clock first passes through a programmable prescaler, which divides it by (prescale + 1) to give an internal module tick. Two count values then set how many module ticks the clock stays low and how many it stays high. Each phase also carries a fixed extra delay `d` that depends on the prescale value. The line is open-drain, so the block only asserts a drive-low enable, and it releases the line for the whole of the high phase.

Software loads the three 16-bit values through a small write/read port. The values in use are copied into an active set only while the module-run input is low. They are frozen while it is high, so a write that lands in the middle of a run takes effect at the next release of the run input. The master state machine gates the clock with an enable. Every time the clock becomes active it starts with a full low phase, and a one-cycle strobe marks the first cycle of each phase.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_drive_low`, `low_phase_stb` and `high_phase_stb` are 0, and every register reads back 0.
- R2: A write with `cfg_sel` = 0 sets the low count, 1 sets the high count and 2 sets the prescale value, and each reads back on `cfg_rdata` with the same select. Select 3 reads 0, and writes to it change nothing.
- R3: While `mod_run` is 0 or `scl_en` is 0, the line is released (`scl_drive_low` = 0) and neither strobe pulses.
- R4: In the first cycle where `mod_run` and `scl_en` are both 1, the line is still released. From the next cycle the low phase begins, and `low_phase_stb` is 1 in that first low cycle.
- R5: Each low phase lasts (P + 1) × (L + d) clock cycles, where P is the prescale value and L the low count, and it repeats every period.
- R6: Each high phase lasts (P + 1) × (H + d) clock cycles, where H is the high count.
- R7: The offset d is 7 when P = 0, 6 when P = 1 and 5 when P ≥ 2.
- R8: Values written while `mod_run` is 1 have no effect on the clock until `mod_run` has been 0 for at least one cycle and is set to 1 again.
- R9: Dropping `scl_en` releases the line in the next cycle. When it is raised again, the clock restarts with a full-length low phase.
- R10: `high_phase_stb` is 1 only in the first cycle of each high phase, `low_phase_stb` only in the first cycle of each low phase, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_run | input | 1 | Module run: 0 holds the divider in reset and loads the active values |
| scl_en | input | 1 | Clock enable from the master state machine |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 low count, 1 high count, 2 prescale |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Read data for the selected programmed register |
| scl_drive_low | output | 1 | Pulls the open-drain line low when 1 |
| low_phase_stb | output | 1 | Pulses in the first cycle of a low phase |
| high_phase_stb | output | 1 | Pulses in the first cycle of a high phase |

## Verification
The bench builds the block with REG_W = 8. This keeps every measured phase down to a few dozen cycles while still reaching all three offset cases: prescale 0, 1, and both 2 and 3 for the "two or more" branch. Count values of 0 are included, so a phase made only of the offset is measured. The short phases also leave room to hit the frozen-value case of R8 and a mid-phase enable drop within the cycle budget.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_PSC  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  // Fixed pipeline offset added to each phase, chosen by prescale value.
  function automatic int unsigned phase_offset(input int unsigned psc);
    if (psc == 0) return 7;
    else if (psc == 1) return 6;
    else return 5;
  endfunction

  // Phase length in module ticks.
  function automatic int unsigned phase_ticks(input int unsigned cnt,
                                              input int unsigned psc);
    return cnt + phase_offset(psc);
  endfunction

  // Full period in system clock cycles.
  function automatic int unsigned period_cycles(input int unsigned psc,
                                                input int unsigned lo,
                                                input int unsigned hi);
    return (psc + 1) * (phase_ticks(lo, psc) + phase_ticks(hi, psc));
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_rate_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_run,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] act_psc,
  output logic [REG_W-1:0] act_low,
  output logic [REG_W-1:0] act_high
);

  logic [REG_W-1:0] prog_psc, prog_low, prog_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_psc  <= '0;
      prog_low  <= '0;
      prog_high <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_LOW:  prog_low  <= wdata;
        SEL_HIGH: prog_high <= wdata;
        SEL_PSC:  prog_psc  <= wdata;
        default:  ;
      endcase
    end
  end

  // Active set follows the programmed set only while held in module reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_psc  <= '0;
      act_low  <= '0;
      act_high <= '0;
    end else if (!mod_run) begin
      act_psc  <= prog_psc;
      act_low  <= prog_low;
      act_high <= prog_high;
    end
  end

  always_comb begin
    case (cfg_sel_e'(sel))
      SEL_LOW:  rdata = prog_low;
      SEL_HIGH: rdata = prog_high;
      SEL_PSC:  rdata = prog_psc;
      default:  rdata = '0;
    endcase
  end

  // R8
  act_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mod_run |=> ($stable(act_psc) && $stable(act_low) && $stable(act_high)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REG_W-1:0] psc,
  output logic             tick
);

  logic [REG_W-1:0] div_cnt;
  logic             at_limit;

  assign at_limit = (div_cnt == psc);
  assign tick     = run && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (!run)     div_cnt <= '0;
    else if (at_limit) div_cnt <= '0;
    else               div_cnt <= div_cnt + REG_W'(1);
  end

  // R5
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_cnt <= psc));

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (psc != '0)) |=> !tick);

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  output logic             started,
  output logic             scl_low,
  output logic             low_stb,
  output logic             high_stb
);

  logic [LEN_W-1:0] ph_cnt;
  logic [LEN_W-1:0] cur_len;
  logic             phase_end;

  assign cur_len   = scl_low ? low_len : high_len;
  assign phase_end = tick && (ph_cnt == cur_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= 1'b0;
      scl_low  <= 1'b0;
      ph_cnt   <= '0;
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
    end else if (!active) begin
      started  <= 1'b0;
      scl_low  <= 1'b0;
      ph_cnt   <= '0;
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
    end else if (!started) begin
      started  <= 1'b1;
      scl_low  <= 1'b1;
      ph_cnt   <= '0;
      low_stb  <= 1'b1;
      high_stb <= 1'b0;
    end else begin
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      if (phase_end) begin
        scl_low  <= ~scl_low;
        ph_cnt   <= '0;
        low_stb  <= ~scl_low;
        high_stb <= scl_low;
      end else if (tick) begin
        ph_cnt <= ph_cnt + LEN_W'(1);
      end
    end
  end

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!scl_low && !low_stb && !high_stb));

  // R10
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_stb && high_stb));

  // R10
  low_stb_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_stb |-> scl_low);

  // R10
  high_stb_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_stb |-> !scl_low);

  // R5
  ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (ph_cnt < cur_len));

  // R6
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && started && !tick) |=> $stable(scl_low));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_run,
  input  logic             scl_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             scl_drive_low,
  output logic             low_phase_stb,
  output logic             high_phase_stb
);

  localparam int LEN_W = REG_W + 1;

  logic [REG_W-1:0] act_psc, act_low, act_high;
  logic [LEN_W-1:0] low_len, high_len;
  logic             active, started, div_run, tick;

  assign active  = mod_run && scl_en;
  assign div_run = active && started;

  assign low_len  = LEN_W'(phase_ticks(32'(act_low),  32'(act_psc)));
  assign high_len = LEN_W'(phase_ticks(32'(act_high), 32'(act_psc)));

  scl_cfg_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_run  (mod_run),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .act_psc  (act_psc),
    .act_low  (act_low),
    .act_high (act_high)
  );

  scl_prescaler #(.REG_W(REG_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (div_run),
    .psc   (act_psc),
    .tick  (tick)
  );

  scl_phase_ctl #(.LEN_W(LEN_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .tick     (tick),
    .low_len  (low_len),
    .high_len (high_len),
    .started  (started),
    .scl_low  (scl_drive_low),
    .low_stb  (low_phase_stb),
    .high_stb (high_phase_stb)
  );

  // R7
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((low_len - LEN_W'(act_low)) >= LEN_W'(5)) &&
    ((low_len - LEN_W'(act_low)) <= LEN_W'(7)));

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !started) |=> (scl_drive_low && low_phase_stb));

endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  localparam int W = 8;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_run = 1'b0, scl_en = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [W-1:0] cfg_wdata = '0;
  logic [W-1:0] cfg_rdata;
  logic scl_drive_low, low_phase_stb, high_phase_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  scl_rate_gen #(.REG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_run(mod_run), .scl_en(scl_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .scl_drive_low(scl_drive_low),
    .low_phase_stb(low_phase_stb), .high_phase_stb(high_phase_stb)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int exp_len(input int psc, input int cnt);
    int d;
    d = (psc >= 2) ? 5 : 7 - psc;
    return (psc + 1) * (cnt + d);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int sel, output int val);
    cfg_sel = 2'(sel);
    #1;
    val = int'(cfg_rdata);
  endtask

  // count cycles while drive_low equals lvl, starting at a negedge
  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (scl_drive_low === lvl && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic start_run(input int psc, input int lo, input int hi);
    @(negedge clk);
    mod_run = 1'b0; scl_en = 1'b0;
    wr(0, lo); wr(1, hi); wr(2, psc);
    @(negedge clk);
    @(negedge clk);
    mod_run = 1'b1; scl_en = 1'b1;
    #1;
    chk(scl_drive_low == 1'b0, "R4 first active cycle released", int'(scl_drive_low), 0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    chk(scl_drive_low == 0 && low_phase_stb == 0 && high_phase_stb == 0,
        "R1 outputs after reset", int'({scl_drive_low, low_phase_stb, high_phase_stb}), 0);
    for (int s = 0; s < 4; s++) begin
      rd(s, v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
  endtask

  task automatic t_regs;
    int v;
    wr(0, 8'h35); wr(1, 8'h4c); wr(2, 8'h02);
    rd(0, v); chk(v == 8'h35, "R2 low count readback", v, 8'h35);
    rd(1, v); chk(v == 8'h4c, "R2 high count readback", v, 8'h4c);
    rd(2, v); chk(v == 8'h02, "R2 prescale readback", v, 8'h02);
    wr(3, 8'haa);
    rd(3, v); chk(v == 0, "R2 select 3 reads zero", v, 0);
    rd(0, v); chk(v == 8'h35, "R2 select 3 write ignored (low)", v, 8'h35);
    rd(1, v); chk(v == 8'h4c, "R2 select 3 write ignored (high)", v, 8'h4c);
    rd(2, v); chk(v == 8'h02, "R2 select 3 write ignored (psc)", v, 8'h02);
  endtask

  task automatic t_idle;
    int bad;
    bad = 0;
    wr(0, 0); wr(1, 0); wr(2, 0);
    mod_run = 1'b0; scl_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_drive_low || low_phase_stb || high_phase_stb) bad++;
    end
    chk(bad == 0, "R3 held while mod_run low", bad, 0);
    bad = 0;
    mod_run = 1'b1; scl_en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_drive_low || low_phase_stb || high_phase_stb) bad++;
    end
    chk(bad == 0, "R3 held while enable low", bad, 0);
    mod_run = 1'b0;
  endtask

  task automatic t_period(input int psc, input int lo, input int hi);
    int n;
    start_run(psc, lo, hi);
    chk(low_phase_stb == 1 && scl_drive_low == 1, "R4 low phase first with strobe",
        int'({low_phase_stb, scl_drive_low}), 3);
    measure(1'b1, n);
    chk(n == exp_len(psc, lo), "R5 R7 low phase length", n, exp_len(psc, lo));
    chk(high_phase_stb == 1 && low_phase_stb == 0, "R10 high strobe at high start",
        int'({high_phase_stb, low_phase_stb}), 2);
    @(negedge clk);
    chk(high_phase_stb == 0, "R10 high strobe one cycle", int'(high_phase_stb), 0);
    measure(1'b0, n);
    chk(n + 1 == exp_len(psc, hi), "R6 R7 high phase length", n + 1, exp_len(psc, hi));
    chk(low_phase_stb == 1, "R10 low strobe at low start", int'(low_phase_stb), 1);
    measure(1'b1, n);
    chk(n == exp_len(psc, lo), "R5 second low phase length", n, exp_len(psc, lo));
    scl_en = 1'b0; mod_run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_shadow;
    int n;
    start_run(0, 3, 4);
    measure(1'b1, n);
    chk(n == 10, "R5 low length before update", n, 10);
    wr(0, 9);
    measure(1'b0, n);
    measure(1'b1, n);
    chk(n == 10, "R8 write during run has no effect", n, 10);
    mod_run = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 0, "R3 release on mod_run drop", int'(scl_drive_low), 0);
    @(negedge clk);
    mod_run = 1'b1;
    @(negedge clk);
    measure(1'b1, n);
    chk(n == 16, "R8 new value after run release", n, 16);
    scl_en = 1'b0; mod_run = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_en_drop;
    int n;
    start_run(1, 4, 4);
    for (int i = 0; i < 5; i++) @(negedge clk);
    scl_en = 1'b0;
    @(negedge clk);
    chk(scl_drive_low == 0 && low_phase_stb == 0 && high_phase_stb == 0,
        "R9 release after enable drop", int'({scl_drive_low, low_phase_stb, high_phase_stb}), 0);
    scl_en = 1'b1;
    @(negedge clk);
    chk(low_phase_stb == 1, "R9 restart strobe", int'(low_phase_stb), 1);
    measure(1'b1, n);
    chk(n == exp_len(1, 4), "R9 full low after restart", n, exp_len(1, 4));
    scl_en = 1'b0; mod_run = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_idle();
    t_period(0, 3, 4);
    t_period(1, 2, 5);
    t_period(2, 0, 1);
    t_period(3, 5, 2);
    t_shadow();
    t_en_drop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule